// File: doc/BRIEF.md
# Deferred Condition-Flag Rebuilder

This unit recreates the processor condition-code word from a recorded description of the last flag-setting operation. The operation description consists of an operation class, an operand width, the source, destination and result values, and the upper product word. A core that skips flag computation during normal execution can present these values once the flags are actually needed. One cycle later it reads back the complete condition-code word.

Only the sign bits of the operands and the result are used to derive carry and overflow. Subtract and compare invert the source sign and then invert the carry. Multiplies examine the full double-width product. Writeback is limited by an update mask. The extended-arithmetic bit always takes part in writeback and is always cleared. While extended arithmetic is active, a zero flag that is already clear stays clear.

Top module: `ccflag_eval`

## Requirements
- R1: The condition-code output `ccs_out` is 0 whenever `rst` was high at the previous rising edge, whatever the other inputs are.
- R2: Add class (`op_class`=1, and the unused code 7). The sign bit is bit 7 for `opnd_size`=0, bit 15 for `opnd_size`=1, and bit 31 for `opnd_size`=2 or 3. If the result sign is 1, N (bit 3) is set. V (bit 1) is set if both operand signs are 0. C (bit 0) is set if both operand signs are 1.
- R3: Add class with result sign 0. Z (bit 2) is set when the result, truncated to the operand width, is zero. V is set when both operand signs are 1. C is set when either operand sign is 1. Result bits above the operand width are ignored.
- R4: Subtract/compare (`op_class`=2). The source sign is inverted before the R2/R3 rules are applied, and the C flag produced by those rules is then inverted.
- R5: Multiply-copy (`op_class`=3). The R2/R3 rules apply, but the carry-style result goes to bit 8. The flag value for C is 0.
- R6: Move/logic/shift (`op_class`=0). N is the truncated result sign. Z is set only if N is 0 and the truncated result is zero. V and C have flag value 0.
- R7: Signed multiply (`op_class`=4), with the operand width ignored. The 64-bit value is {`mul_hi`,`res_val`}. Z is set if this value is zero, N is its bit 63, and V is set when `mul_hi` is not the sign extension of `res_val`.
- R8: Unsigned multiply (`op_class`=5). Z is set if the 64-bit product is zero, N is product bit 63, and V is set if `mul_hi` is nonzero.
- R9: Outside live mode, the output bits in (`upd_mask` | bit 4) take the new flag values. All other bits are copied from `ccs_in`.
- R10: When `ext_x` is 1 and the new Z is 1, Z is excluded from writeback and copied from `ccs_in`. When the new Z is 0, Z is written normally.
- R11: Outside live mode, bit 4 (X) of the output is always 0.
- R12: Live flags (`op_class`=6). The output equals `ccs_in` unchanged, including bit 4.
- R13: While `eval_en` is 0, the output holds its value.
- R14: With `eval_en` high, the output carries the result one rising edge after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_en | input | 1 | Load a new condition-code word |
| op_class | input | 3 | Recorded operation class |
| opnd_size | input | 2 | Operand width: 0 byte, 1 half, 2/3 word |
| src_val | input | DW | Recorded source operand |
| dst_val | input | DW | Recorded destination operand |
| res_val | input | DW | Recorded result (low product word) |
| mul_hi | input | DW | Upper product word |
| ccs_in | input | CW | Current condition-code word |
| upd_mask | input | CW | Bits allowed to change |
| ext_x | input | 1 | Extended arithmetic active |
| ccs_out | output | CW | Rebuilt condition-code word |

## Verification
The sticky-zero case is the hardest to reach. It requires `ext_x` high, a recorded operation whose new Z is 1, and a `ccs_in` with Z clear, all at once. The stimulus sets up both halves on purpose: one vector has a zero result and a clear incoming Z, so Z must stay clear. A second vector has a nonzero result and a set incoming Z, so Z must be cleared. Further vectors place sign-carrying bits just above the byte and half widths, so that a wrong sign-bit pick or truncation becomes visible.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  typedef enum logic [2:0] {
    OPC_MOVE = 3'd0,
    OPC_ADD  = 3'd1,
    OPC_SUB  = 3'd2,
    OPC_MCP  = 3'd3,
    OPC_MULS = 3'd4,
    OPC_MULU = 3'd5,
    OPC_LIVE = 3'd6,
    OPC_RSVD = 3'd7
  } ccf_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } ccf_size_e;

  localparam int unsigned BIT_C = 0;
  localparam int unsigned BIT_V = 1;
  localparam int unsigned BIT_Z = 2;
  localparam int unsigned BIT_N = 3;
  localparam int unsigned BIT_X = 4;
  localparam int unsigned BIT_R = 8;
  localparam int unsigned N_OPND = 3;
endpackage

// File: rtl/ccf_size_view.sv
module ccf_size_view #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] val,
  input  logic [1:0]    size,
  output logic          sign,
  output logic          is_zero
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;

  always_comb begin
    case (size)
      2'd0: begin
        sign    = val[BYTE_W-1];
        is_zero = (val[BYTE_W-1:0] == '0);
      end
      2'd1: begin
        sign    = val[HALF_W-1];
        is_zero = (val[HALF_W-1:0] == '0);
      end
      default: begin
        sign    = val[DW-1];
        is_zero = (val == '0);
      end
    endcase
  end
endmodule

// File: rtl/ccf_arith_flags.sv
module ccf_arith_flags (
  input  logic src_s,
  input  logic dst_s,
  input  logic res_s,
  input  logic res_z,
  input  logic borrow_mode,
  output logic fl_n,
  output logic fl_z,
  output logic fl_v,
  output logic fl_cy
);
  logic cy_raw;

  always_comb begin
    fl_n   = 1'b0;
    fl_z   = 1'b0;
    fl_v   = 1'b0;
    cy_raw = 1'b0;
    if (res_s) begin
      fl_n = 1'b1;
      if (!src_s && !dst_s)
        fl_v = 1'b1;
      else if (src_s && dst_s)
        cy_raw = 1'b1;
    end else begin
      fl_z   = res_z;
      fl_v   = src_s && dst_s;
      cy_raw = src_s || dst_s;
    end
    fl_cy = cy_raw ^ borrow_mode;
  end
endmodule

// File: rtl/ccf_mul_flags.sv
module ccf_mul_flags #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] lo_word,
  input  logic [DW-1:0] hi_word,
  input  logic          signed_mode,
  output logic          fl_n,
  output logic          fl_z,
  output logic          fl_v
);
  localparam int unsigned PW = 2 * DW;
  logic [PW-1:0] prod;

  always_comb begin
    prod = {hi_word, lo_word};
    fl_z = (prod == '0);
    fl_n = prod[PW-1];
    if (signed_mode)
      fl_v = (hi_word != {DW{lo_word[DW-1]}});
    else
      fl_v = (hi_word != '0);
  end
endmodule

// File: rtl/ccf_writeback.sv
module ccf_writeback
  import ccf_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic [CW-1:0] ccs_cur,
  input  logic [CW-1:0] new_flags,
  input  logic [CW-1:0] upd_mask,
  input  logic          ext_x,
  output logic [CW-1:0] ccs_next
);
  logic [CW-1:0] eff_mask;

  always_comb begin
    eff_mask        = upd_mask;
    eff_mask[BIT_X] = 1'b1;
    if (ext_x && new_flags[BIT_Z])
      eff_mask[BIT_Z] = 1'b0;
    ccs_next = (ccs_cur & ~eff_mask) | (new_flags & eff_mask);
  end
endmodule

// File: rtl/ccflag_eval.sv
module ccflag_eval
  import ccf_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eval_en,
  input  logic [2:0]    op_class,
  input  logic [1:0]    opnd_size,
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] dst_val,
  input  logic [DW-1:0] res_val,
  input  logic [DW-1:0] mul_hi,
  input  logic [CW-1:0] ccs_in,
  input  logic [CW-1:0] upd_mask,
  input  logic          ext_x,
  output logic [CW-1:0] ccs_out
);
  ccf_op_e       opc;
  logic          is_sub;
  logic [DW-1:0] opnd [N_OPND];
  logic          opnd_sign [N_OPND];
  logic          opnd_zero [N_OPND];
  logic          ar_n, ar_z, ar_v, ar_cy;
  logic          mu_n, mu_z, mu_v;
  logic [CW-1:0] flags;
  logic [CW-1:0] wb_ccs;
  logic [CW-1:0] ccs_q;

  assign opc     = ccf_op_e'(op_class);
  assign is_sub  = (opc == OPC_SUB);
  assign opnd[0] = is_sub ? ~src_val : src_val;
  assign opnd[1] = dst_val;
  assign opnd[2] = res_val;

  for (genvar g = 0; g < N_OPND; g++) begin : g_view
    ccf_size_view #(.DW(DW)) u_view (
      .val     (opnd[g]),
      .size    (opnd_size),
      .sign    (opnd_sign[g]),
      .is_zero (opnd_zero[g])
    );
  end

  ccf_arith_flags u_arith (
    .src_s       (opnd_sign[0]),
    .dst_s       (opnd_sign[1]),
    .res_s       (opnd_sign[2]),
    .res_z       (opnd_zero[2]),
    .borrow_mode (is_sub),
    .fl_n        (ar_n),
    .fl_z        (ar_z),
    .fl_v        (ar_v),
    .fl_cy       (ar_cy)
  );

  ccf_mul_flags #(.DW(DW)) u_mul (
    .lo_word     (res_val),
    .hi_word     (mul_hi),
    .signed_mode (opc == OPC_MULS),
    .fl_n        (mu_n),
    .fl_z        (mu_z),
    .fl_v        (mu_v)
  );

  always_comb begin
    flags = '0;
    case (opc)
      OPC_MOVE: begin
        flags[BIT_N] = opnd_sign[2];
        flags[BIT_Z] = !opnd_sign[2] && opnd_zero[2];
      end
      OPC_MULS, OPC_MULU: begin
        flags[BIT_N] = mu_n;
        flags[BIT_Z] = mu_z;
        flags[BIT_V] = mu_v;
      end
      OPC_MCP: begin
        flags[BIT_N] = ar_n;
        flags[BIT_Z] = ar_z;
        flags[BIT_V] = ar_v;
        flags[BIT_R] = ar_cy;
      end
      default: begin
        flags[BIT_N] = ar_n;
        flags[BIT_Z] = ar_z;
        flags[BIT_V] = ar_v;
        flags[BIT_C] = ar_cy;
      end
    endcase
  end

  ccf_writeback #(.CW(CW)) u_wb (
    .ccs_cur   (ccs_in),
    .new_flags (flags),
    .upd_mask  (upd_mask),
    .ext_x     (ext_x),
    .ccs_next  (wb_ccs)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ccs_q <= '0;
    else if (eval_en)
      ccs_q <= (opc == OPC_LIVE) ? ccs_in : wb_ccs;
  end

  assign ccs_out = ccs_q;

  // R1: reset clears the output
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ccs_out == '0));

  // R13: output holds while not enabled
  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !eval_en |=> $stable(ccs_out));

  // R12: live class passes the incoming word through
  assert_live_pass_R12: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class == 3'd6) |=> (ccs_out == $past(ccs_in)));

  // R11: extended bit cleared on every evaluating class
  assert_x_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class != 3'd6) |=> !ccs_out[BIT_X]);

  // R9: bits outside the update mask follow ccs_in
  assert_mask_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class != 3'd6) |=>
      ((ccs_out & ~$past(upd_mask) & ~(CW'(1) << BIT_X)) ==
       ($past(ccs_in) & ~$past(upd_mask) & ~(CW'(1) << BIT_X))));

  // R10: a clear Z stays clear under extended arithmetic
  assert_sticky_z_R10: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class != 3'd6 && ext_x && !ccs_in[BIT_Z]) |=> !ccs_out[BIT_Z]);

  // R5: multiply-copy never writes a 1 into C
  assert_mcp_no_c_R5: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class == 3'd3) |=>
      (ccs_out[BIT_C] == ($past(ccs_in[BIT_C]) && !$past(upd_mask[BIT_C]))));

  // R8: unsigned multiply with nonzero upper word flags overflow
  assert_mulu_v_R8: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class == 3'd5 && mul_hi != '0 && upd_mask[BIT_V]) |=> ccs_out[BIT_V]);

  // R6: move class never reports N and Z together
  assert_move_excl_R6: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class == 3'd0 && upd_mask[BIT_N] && upd_mask[BIT_Z]) |=>
      !(ccs_out[BIT_N] && ccs_out[BIT_Z]));
endmodule

// File: tb/ccflag_eval_tb.sv
`timescale 1ns/1ps
module ccflag_eval_tb_top;
  localparam int DW = 32;
  localparam int CW = 32;
  localparam int NV = 25;
  localparam int VW = 238;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          eval_en = 1'b0;
  logic [2:0]    op_class = '0;
  logic [1:0]    opnd_size = '0;
  logic [DW-1:0] src_val = '0, dst_val = '0, res_val = '0, mul_hi = '0;
  logic [CW-1:0] ccs_in = '0, upd_mask = '0;
  logic          ext_x = 1'b0;
  logic [CW-1:0] ccs_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ccflag_eval #(.DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .eval_en(eval_en), .op_class(op_class),
    .opnd_size(opnd_size), .src_val(src_val), .dst_val(dst_val),
    .res_val(res_val), .mul_hi(mul_hi), .ccs_in(ccs_in),
    .upd_mask(upd_mask), .ext_x(ext_x), .ccs_out(ccs_out)
  );

  // {tag, op, size, src, dst, res, hi, ccs_in, mask, x, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'd2,  3'd1, 2'd2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h0A}, // R2
    {8'd3,  3'd1, 2'd2, 32'h80000000, 32'h80000000, 32'h00000000, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h07}, // R3
    {8'd2,  3'd1, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h09}, // R2
    {8'd3,  3'd1, 2'd0, 32'h000000FF, 32'h00000001, 32'h00000100, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h05}, // R3 byte
    {8'd2,  3'd1, 2'd1, 32'h00007000, 32'h00001000, 32'h12348000, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h0A}, // R2 half
    {8'd2,  3'd7, 2'd3, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h0A}, // R2 code 7, size 3
    {8'd4,  3'd2, 2'd2, 32'h00000001, 32'h00000001, 32'h00000000, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h04}, // R4
    {8'd4,  3'd2, 2'd2, 32'h00000001, 32'h00000000, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h09}, // R4 borrow
    {8'd4,  3'd2, 2'd0, 32'h00000001, 32'h00000080, 32'h0000007F, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h02}, // R4 byte ovf
    {8'd5,  3'd3, 2'd2, 32'h80000000, 32'h80000000, 32'h00000000, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h106}, // R5
    {8'd5,  3'd3, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h0, 32'h1, 32'h10F, 1'b0, 32'h108}, // R5
    {8'd6,  3'd0, 2'd2, 32'h80000000, 32'h80000000, 32'h80000000, 32'h0, 32'h3, 32'h10F, 1'b0, 32'h08}, // R6
    {8'd6,  3'd0, 2'd1, 32'h0, 32'h0, 32'hFFFF0000, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h04}, // R6 half
    {8'd6,  3'd0, 2'd0, 32'h0, 32'h0, 32'h00000080, 32'h0, 32'h0, 32'h10F, 1'b0, 32'h08}, // R6 byte
    {8'd7,  3'd4, 2'd2, 32'h0, 32'h0, 32'h80000000, 32'hFFFFFFFF, 32'h0, 32'h10F, 1'b0, 32'h08}, // R7
    {8'd7,  3'd4, 2'd2, 32'h0, 32'h0, 32'h00000001, 32'hFFFFFFFF, 32'h0, 32'h10F, 1'b0, 32'h0A}, // R7 ovf
    {8'd7,  3'd4, 2'd0, 32'h0, 32'h0, 32'h00000000, 32'h00000000, 32'h0, 32'h10F, 1'b0, 32'h04}, // R7 zero
    {8'd8,  3'd5, 2'd2, 32'h0, 32'h0, 32'h00000000, 32'h80000000, 32'h0, 32'h10F, 1'b0, 32'h0A}, // R8
    {8'd8,  3'd5, 2'd2, 32'h0, 32'h0, 32'h00000005, 32'h00000000, 32'h0, 32'h10F, 1'b0, 32'h00}, // R8
    {8'd9,  3'd1, 2'd2, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 32'hFFFF0000, 32'h3, 1'b0, 32'hFFFF0003}, // R9
    {8'd10, 3'd1, 2'd2, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 32'h10, 32'hF, 1'b1, 32'h03}, // R10 sticky
    {8'd10, 3'd1, 2'd2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 32'h14, 32'hF, 1'b1, 32'h0A}, // R10 clear
    {8'd11, 3'd5, 2'd2, 32'h0, 32'h0, 32'h5, 32'h0, 32'h10, 32'h0, 1'b0, 32'h0}, // R11
    {8'd12, 3'd6, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h12345677, 32'hFFFFFFFF, 1'b1, 32'h12345677}, // R12
    {8'd11, 3'd0, 2'd2, 32'h0, 32'h0, 32'h1, 32'h0, 32'hABCD0010, 32'h0, 1'b0, 32'hABCD0000} // R11
  };

  task automatic check(input int req, input logic [CW-1:0] exp);
    n_chk++;
    if (ccs_out !== exp) begin
      n_fail++;
      $display("FAIL R%0d: ccs_out=%08h expected=%08h", req, ccs_out, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    op_class  = v[229:227];
    opnd_size = v[226:225];
    src_val   = v[224:193];
    dst_val   = v[192:161];
    res_val   = v[160:129];
    mul_hi    = v[128:97];
    ccs_in    = v[96:65];
    upd_mask  = v[64:33];
    ext_x     = v[32];
  endtask

  initial begin
    eval_en = 1'b1;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    check(1, 32'h0);  // R1: reset wins over eval_en
    rst = 1'b0;
    // R14: value appears only after the next edge
    check(14, 32'h0);
    @(negedge clk);
    check(14, 32'h0A);
    // R13: hold while disabled
    eval_en = 1'b0;
    drive(VEC[1]);
    @(negedge clk);
    check(13, 32'h0A);
    eval_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check(int'(VEC[i][237:230]), VEC[i][31:0]);
    end
    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check(1, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule